// File: doc/BRIEF.md
# Sequential Signed/Unsigned Long Divider with Status Flags

This unit sits beside the integer datapath of a 32-bit processor and performs a long division: a double-width dividend is divided by a single-width divisor, one quotient bit per clock. The dividend is formed by placing an extension word above a data word. When the operation ends, the low word of the quotient is meant to go back into the data register and the remainder into the extension register. The unit also presents four fresh status flags. A control input chooses between two's-complement and unsigned interpretation of the operands.

A zero divisor is not trapped. The unit finishes in one cycle with a fixed sentinel quotient and with the original data word as the remainder, and it raises overflow. The flags are always derived from the quotient word that the unit returns. The caller asserts `start_i` while the unit is idle and waits for the one-cycle `done_o` pulse. The result and flag outputs then hold their values until the next operation completes.

Top module: `mdiv_unit`

## Requirements
- R1: The dividend is {ext_i, data_i}, with ext_i as the upper word. In unsigned mode (signed_i=0), quo_o equals the low W bits of dividend / dsr_i and rem_o equals dividend % dsr_i. All operands are sampled in the cycle in which start is accepted.
- R2: In signed mode (signed_i=1), the dividend and the divisor are two's-complement values. The quotient truncates toward zero, and the remainder is zero or carries the dividend's sign.
- R3: Quotient bits above the low W bits are discarded. A divide by a non-zero divisor always returns flags_o[3] (overflow) = 0.
- R4: With dsr_i = 0, quo_o becomes the sentinel 0x000000FF, rem_o becomes the data_i word, and flags_o[3] = 1. This holds in both modes.
- R5: A zero-divisor divide raises done_o in the cycle after start is accepted, and busy_o stays low throughout.
- R6: flags_o[0] (zero) is 1 exactly when the returned quo_o is 0, and this includes the zero-divisor case.
- R7: flags_o[1] (negative) equals bit W-1 of the returned quo_o.
- R8: flags_o[2] (carry) is 0 after every divide. All four flags are rewritten at completion.
- R9: A divide by a non-zero divisor raises busy_o in the cycle after acceptance. busy_o then stays high for 2W+1 cycles, and done_o rises as busy_o falls.
- R10: start_i is ignored while busy_o is high. Neither the outputs nor the running divide are disturbed.
- R11: Synchronous reset clears busy_o, done_o and flags_o, and it aborts a running divide.
- R12: done_o is a single-cycle pulse. A new start may be accepted in the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a divide; accepted only when idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| ext_i | input | W | Upper word of the dividend |
| data_i | input | W | Lower word of the dividend |
| dsr_i | input | W | Divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle pulse: results and flags are valid |
| quo_o | output | W | Low word of the quotient, or the sentinel |
| rem_o | output | W | Remainder, or the original data word |
| flags_o | output | 4 | [3] overflow, [2] carry, [1] negative, [0] zero |

## Verification
The assertions assume three things about the inputs. First, operands need only be stable in the cycle in which start is accepted, because the zero-divisor checks refer to the data word of that cycle. Second, start may be high at any time, including while busy. Third, reset is synchronous. The stimulus changes the operands to unrelated values immediately after every accepted start. It also pulses start in the middle of a running divide and again in the completion cycle, and it applies reset during an iteration. This shows that no requirement depends on the operands being held.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOP  = 2'd1,
        ST_FINAL = 2'd2
    } mdiv_state_e;

    typedef struct packed {
        logic ovf;
        logic cry;
        logic neg;
        logic zro;
    } mdiv_flags_t;

    localparam int FLAG_W = $bits(mdiv_flags_t);

    function automatic mdiv_flags_t mdiv_make_flags(input logic is_zero,
                                                     input logic msb,
                                                     input logic div0);
        mdiv_flags_t f;
        f.ovf = div0;
        f.cry = 1'b0;
        f.neg = msb;
        f.zro = is_zero;
        return f;
    endfunction

endpackage

// File: rtl/mdiv_prep.sv
module mdiv_prep #(
    parameter int W = 32
) (
    input  logic             signed_mode,
    input  logic [W-1:0]     ext_i,
    input  logic [W-1:0]     data_i,
    input  logic [W-1:0]     dsr_i,
    output logic [2*W-1:0]   dvd_mag,
    output logic [W-1:0]     dsr_mag,
    output logic             quo_neg,
    output logic             rem_neg,
    output logic             dsr_zero
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd;
    logic          dvd_sgn;
    logic          dsr_sgn;

    assign dvd     = {ext_i, data_i};
    assign dvd_sgn = signed_mode & dvd[DW-1];
    assign dsr_sgn = signed_mode & dsr_i[W-1];

    assign dvd_mag  = dvd_sgn ? (~dvd + {{(DW-1){1'b0}}, 1'b1}) : dvd;
    assign dsr_mag  = dsr_sgn ? (~dsr_i + {{(W-1){1'b0}}, 1'b1}) : dsr_i;
    assign quo_neg  = dvd_sgn ^ dsr_sgn;
    assign rem_neg  = dvd_sgn;
    assign dsr_zero = (dsr_i == '0);

endmodule

// File: rtl/mdiv_core.sv
module mdiv_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [2*W-1:0] dvd_mag,
    input  logic [W-1:0]   dsr_mag,
    output logic [W-1:0]   quo_lo,
    output logic [W-1:0]   rem_mag,
    output logic           last_step
);
    localparam int DW   = 2 * W;
    localparam int ITER = DW;
    localparam int CW   = $clog2(ITER + 1);

    logic [DW-1:0] quo_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt_q;

    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          fits;
    logic [W-1:0]  rem_n;
    logic [DW-1:0] quo_n;

    // one restoring step: bring in the next dividend bit, subtract if it fits
    assign shifted = {rem_q, quo_q[DW-1]};
    assign fits    = (shifted >= {1'b0, dsr_q});
    assign diff    = shifted - {1'b0, dsr_q};
    assign rem_n   = fits ? diff[W-1:0] : shifted[W-1:0];
    assign quo_n   = {quo_q[DW-2:0], fits};

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            quo_q <= dvd_mag;
            rem_q <= '0;
            dsr_q <= dsr_mag;
            cnt_q <= CW'(ITER);
        end else if (cnt_q != '0) begin
            quo_q <= quo_n;
            rem_q <= rem_n;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign quo_lo    = quo_q[W-1:0];
    assign rem_mag   = rem_q;
    assign last_step = (cnt_q == CW'(1));

endmodule

// File: rtl/mdiv_post.sv
module mdiv_post
    import mdiv_pkg::*;
#(
    parameter int           W    = 32,
    parameter logic [W-1:0] SENT = 'hFF
) (
    input  logic        div0,
    input  logic        quo_neg,
    input  logic        rem_neg,
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic [W-1:0] data_raw,
    output logic [W-1:0] quo_word,
    output logic [W-1:0] rem_word,
    output mdiv_flags_t  flags
);
    logic [W-1:0] quo_fix;
    logic [W-1:0] rem_fix;

    // low word of a two's-complement negation depends only on the low word
    assign quo_fix  = quo_neg ? (~quo_mag + {{(W-1){1'b0}}, 1'b1}) : quo_mag;
    assign rem_fix  = rem_neg ? (~rem_mag + {{(W-1){1'b0}}, 1'b1}) : rem_mag;

    assign quo_word = div0 ? SENT : quo_fix;
    assign rem_word = div0 ? data_raw : rem_fix;
    assign flags    = mdiv_make_flags(quo_word == '0, quo_word[W-1], div0);

endmodule

// File: rtl/mdiv_unit.sv
module mdiv_unit
    import mdiv_pkg::*;
#(
    parameter int           W    = 32,
    parameter logic [W-1:0] SENT = 'hFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          signed_i,
    input  logic [W-1:0]  ext_i,
    input  logic [W-1:0]  data_i,
    input  logic [W-1:0]  dsr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  quo_o,
    output logic [W-1:0]  rem_o,
    output logic [3:0]    flags_o
);
    mdiv_state_e   state_q;
    logic          quo_neg_q;
    logic          rem_neg_q;
    logic          done_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  rem_q;
    mdiv_flags_t   flags_q;

    logic [2*W-1:0] dvd_mag;
    logic [W-1:0]   dsr_mag;
    logic           quo_neg_c;
    logic           rem_neg_c;
    logic           dsr_zero;
    logic [W-1:0]   core_quo;
    logic [W-1:0]   core_rem;
    logic           last_step;
    logic [W-1:0]   post_quo;
    logic [W-1:0]   post_rem;
    mdiv_flags_t    post_flags;
    logic           accept;
    logic           idle;

    assign idle   = (state_q == ST_IDLE);
    assign accept = start_i && idle;

    mdiv_prep #(.W(W)) prep_i (
        .signed_mode (signed_i),
        .ext_i       (ext_i),
        .data_i      (data_i),
        .dsr_i       (dsr_i),
        .dvd_mag     (dvd_mag),
        .dsr_mag     (dsr_mag),
        .quo_neg     (quo_neg_c),
        .rem_neg     (rem_neg_c),
        .dsr_zero    (dsr_zero)
    );

    mdiv_core #(.W(W)) core_i (
        .clk       (clk),
        .rst       (rst),
        .load      (accept && !dsr_zero),
        .dvd_mag   (dvd_mag),
        .dsr_mag   (dsr_mag),
        .quo_lo    (core_quo),
        .rem_mag   (core_rem),
        .last_step (last_step)
    );

    // while idle the post stage only serves the zero-divisor shortcut
    mdiv_post #(.W(W), .SENT(SENT)) post_i (
        .div0     (idle),
        .quo_neg  (quo_neg_q),
        .rem_neg  (rem_neg_q),
        .quo_mag  (core_quo),
        .rem_mag  (core_rem),
        .data_raw (data_i),
        .quo_word (post_quo),
        .rem_word (post_rem),
        .flags    (post_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            quo_neg_q <= 1'b0;
            rem_neg_q <= 1'b0;
            done_q    <= 1'b0;
            quo_q     <= '0;
            rem_q     <= '0;
            flags_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dsr_zero) begin
                            quo_q   <= post_quo;
                            rem_q   <= post_rem;
                            flags_q <= post_flags;
                            done_q  <= 1'b1;
                        end else begin
                            quo_neg_q <= quo_neg_c;
                            rem_neg_q <= rem_neg_c;
                            state_q   <= ST_LOOP;
                        end
                    end
                end
                ST_LOOP: begin
                    if (last_step) begin
                        state_q <= ST_FINAL;
                    end
                end
                ST_FINAL: begin
                    quo_q   <= post_quo;
                    rem_q   <= post_rem;
                    flags_q <= post_flags;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = !idle;
    assign done_o  = done_q;
    assign quo_o   = quo_q;
    assign rem_o   = rem_q;
    assign flags_o = flags_q;

endmodule

// File: rtl/mdiv_chk.sv
module mdiv_chk #(
    parameter int           W    = 32,
    parameter logic [W-1:0] SENT = 'hFF
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         signed_i,
    input logic [W-1:0] ext_i,
    input logic [W-1:0] data_i,
    input logic [W-1:0] dsr_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] quo_o,
    input logic [W-1:0] rem_o,
    input logic [3:0]   flags_o
);
    logic zero_op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_op_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            zero_op_q <= (dsr_i == '0);
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !zero_op_q) |-> !flags_o[3]);

    p_div0_result_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && dsr_i == '0) |=>
            (quo_o == SENT && rem_o == $past(data_i) && flags_o[3]));

    p_div0_fast_r5: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && dsr_i == '0) |=> (done_o && !busy_o));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (flags_o[0] == (quo_o == '0)));

    p_neg_flag_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (flags_o[1] == quo_o[W-1]));

    p_carry_clear_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !flags_o[2]);

    p_busy_rise_r9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && dsr_i != '0) |=> (busy_o && !done_o));

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !done_o);

    p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!done_o && $past(!done_o)) |-> ($stable(quo_o) && $stable(rem_o) && $stable(flags_o)));

    logic unused_ok;
    assign unused_ok = signed_i ^ (|ext_i);

endmodule

bind mdiv_unit mdiv_chk #(.W(W), .SENT(SENT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .signed_i (signed_i),
    .ext_i    (ext_i),
    .data_i   (data_i),
    .dsr_i    (dsr_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .quo_o    (quo_o),
    .rem_o    (rem_o),
    .flags_o  (flags_o)
);

// File: tb/mdiv_unit_tb_top.sv
module mdiv_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int RUN_CYC    = 2 * W + 1;
    localparam int WD_LIMIT   = 150000;

    logic          clk;
    logic          rst;
    logic          start;
    logic          sgn;
    logic [W-1:0]  ext;
    logic [W-1:0]  dat;
    logic [W-1:0]  dsr;
    logic          busy;
    logic          done;
    logic [W-1:0]  quo;
    logic [W-1:0]  rem;
    logic [3:0]    flags;

    mdiv_unit #(.W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .signed_i (sgn),
        .ext_i    (ext),
        .data_i   (dat),
        .dsr_i    (dsr),
        .busy_o   (busy),
        .done_o   (done),
        .quo_o    (quo),
        .rem_o    (rem),
        .flags_o  (flags)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    armed = 0;
    string cur_tag = "R11";

    // reference model state
    bit          m_busy, m_done;
    int          m_cnt;
    logic [31:0] m_q, m_r, p_q, p_r;
    logic [3:0]  m_f, p_f;

    function automatic void ref_div(input bit sm, input logic [31:0] hi, input logic [31:0] lo,
                                    input logic [31:0] d, output logic [31:0] q,
                                    output logic [31:0] r, output logic [3:0] f);
        logic [63:0] num, mn, qq, rr;
        logic [31:0] md;
        bit nd, nv, ov;
        num = {hi, lo};
        nd  = sm && hi[31];
        nv  = sm && d[31];
        mn  = nd ? (64'd0 - num) : num;
        md  = nv ? (32'd0 - d) : d;
        if (d == 32'd0) begin
            q  = 32'h0000_00FF;
            r  = lo;
            ov = 1'b1;
        end else begin
            qq = mn / {32'd0, md};
            rr = mn % {32'd0, md};
            if (nd != nv) qq = 64'd0 - qq;
            if (nd) rr = 64'd0 - rr;
            q  = qq[31:0];
            r  = rr[31:0];
            ov = 1'b0;
        end
        f = {ov, 1'b0, q[31], (q == 32'd0)};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            m_q = '0; m_r = '0; m_f = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    m_q = p_q; m_r = p_r; m_f = p_f;
                end
            end else if (start) begin
                ref_div(sgn, ext, dat, dsr, p_q, p_r, p_f);
                if (dsr == 32'd0) begin
                    m_done = 1;
                    m_q = p_q; m_r = p_r; m_f = p_f;
                end else begin
                    m_busy = 1;
                    m_cnt  = RUN_CYC;
                end
            end
        end
    end

    task automatic chk(input string fld, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", cur_tag, fld, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            chk("busy", 32'(busy), 32'(m_busy));
            chk("done", 32'(done), 32'(m_done));
            chk("quo", quo, m_q);
            chk("rem", rem, m_r);
            chk("flags", 32'(flags), 32'(m_f));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_bad++;
            $display("FAIL R9 watchdog act=hung exp=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic scramble();
        ext = 32'hDEAD_BEEF ^ ext;
        dat = 32'h1357_9BDF ^ dat;
        dsr = 32'hA5A5_0001 ^ dsr;
        sgn = ~sgn;
    endtask

    task automatic wait_idle();
        while (m_busy || m_done) @(negedge clk);
    endtask

    task automatic issue(input bit sm, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] d, input string tag);
        @(negedge clk);
        cur_tag = tag;
        start = 1; sgn = sm; ext = hi; dat = lo; dsr = d;
        @(negedge clk);
        start = 0;
        scramble();
    endtask

    task automatic op(input bit sm, input logic [31:0] hi, input logic [31:0] lo,
                      input logic [31:0] d, input string tag);
        issue(sm, hi, lo, d, tag);
        wait_idle();
    endtask

    logic [31:0] lfsr;

    initial begin
        rst = 1; start = 0; sgn = 0; ext = '0; dat = '0; dsr = '0;
        lfsr = 32'hC0FF_EE01;
        @(posedge clk);
        @(negedge clk);
        armed = 1;          // R11: outputs after reset
        repeat (2) @(negedge clk);
        rst = 0;

        op(0, 32'h0, 32'd100, 32'd7, "R1");
        op(0, 32'h1, 32'h0, 32'h10, "R1");
        op(0, 32'h5, 32'h0, 32'h3, "R3");                       // quotient > 32 bits
        op(1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, "R2");       // -100 / 7
        op(1, 32'h0, 32'd100, 32'hFFFF_FFF9, "R2");             // 100 / -7
        op(1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9, "R7");
        op(1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, "R2");       // most negative / -1
        op(0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, "R4");
        op(1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, "R5");
        op(0, 32'h0, 32'd3, 32'd5, "R6");                       // zero quotient
        op(1, 32'h0, 32'd0, 32'd9, "R8");

        // R10: start pulses while busy
        issue(0, 32'h0, 32'd1000, 32'd3, "R10");
        repeat (10) @(negedge clk);
        start = 1; dsr = 32'd0; dat = 32'h7777_7777;
        @(negedge clk);
        start = 1; dsr = 32'd2;
        repeat (3) @(negedge clk);
        start = 0;
        wait_idle();

        // R12: new start in the completion cycle
        issue(1, 32'h0, 32'd77, 32'd5, "R12");
        while (!m_done) @(negedge clk);
        start = 1; sgn = 0; ext = 32'h2; dat = 32'h9; dsr = 32'h7;
        @(negedge clk);
        start = 0;
        scramble();
        wait_idle();

        // R11: reset in the middle of an iteration
        issue(0, 32'h3, 32'h4, 32'h5, "R11");
        repeat (20) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        op(0, 32'h0, 32'd50, 32'd6, "R9");

        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b, c;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} * 32'd1664525 + 32'd1013904223;
            a = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            b = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            c = (i % 7 == 3) ? 32'd0 : ((i % 3 == 0) ? (lfsr >> (i % 29)) : lfsr);
            op(i[0], (i % 4 == 1) ? (a >> 20) : a, b, c, i[0] ? "R2" : "R1");
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule